// File: doc/BRIEF.md
# Reset Pulse Stretcher with Cause Logging

This block turns a set of reset requests into a single active-low system reset line. The line is open-drain in spirit: the block either pulls the pin low or leaves it alone, and it reads the resulting pin level back. Every accepted request holds the line low for a minimum time, either short or long. The choice comes from a length-select bit that software may clear or set. Hardware forces that bit to the long setting whenever the system sits in a recovery mode. A reset that was wrongly shortened therefore gets a second try with the long pulse.

A numeric cause code is latched with every accepted request, so software can tell afterwards why the system was reset. A falling edge on the pin that the block did not cause counts as an external reset. From that point the block times how long the pin stays low. If the pin is not let go in time, it raises a fail-safe request. After power-up the block holds the line low until the main supply reports valid, then gives one short power-on pulse whatever the length bit says.

Top module: `rststr_top`

## Requirements
- R1: While `rstN` is low and afterwards until `supplyValid` is first seen high, `pinDriveLow` is 1, `sourceCode` is 0, `lenBit` is 0 and `failSafeReq` is 0.
- R2: The first cycle with `supplyValid` high starts a power-on pulse of exactly SHORT_CYCLES cycles with `sourceCode` 1. This happens even when `lenBit` was written to 1 beforehand.
- R3: A request accepted while `lenBit` is 0 holds `pinDriveLow` high for exactly SHORT_CYCLES cycles. A request accepted while `lenBit` is 1 holds it for exactly LONG_CYCLES cycles. The count starts with the cycle after the request strobe.
- R4: `eventReq[i]` logs code 3+i and an external pin reset logs code 2. When several requests arrive in the same cycle, the external reset wins, then the lowest set index of `eventReq`.
- R5: A request that arrives during a pulse restarts the full length, using the `lenBit` value of that cycle. Its code replaces the one logged before.
- R6: With `mode` at 0 (normal), a cycle with `lenWrEn` high loads `lenWrData` into `lenBit`.
- R7: With `mode` at 1 (restart) or 2 (fail-safe), `lenBit` becomes 1 on the next edge and software writes are ignored. It stays 1 after `mode` returns to 0, until software clears it.
- R8: A falling edge of `pinLevel` while the block is not driving starts a pulse with code 2. The two-flop synchronizer adds delay before the pulse starts. The pin going low under the block's own drive, or staying low after the block lets go, starts nothing.
- R9: After an external reset, `failSafeReq` goes to 1 once the pin has stayed low for RELEASE_TIMEOUT cycles. It does not rise if the pin is released earlier. It returns to 0 a few cycles after the pin goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| supplyValid | input | 1 | Main supply is valid |
| eventReq | input | NUM_EVT | One-cycle reset request strobes, one per cause |
| mode | input | 2 | 0 normal, 1 restart, 2 fail-safe |
| lenWrEn | input | 1 | Software write strobe for the length bit |
| lenWrData | input | 1 | Value to write into the length bit |
| pinLevel | input | 1 | Level read back from the reset pin |
| pinDriveLow | output | 1 | 1 pulls the reset pin low |
| sourceCode | output | 4 | Code of the most recent reset cause |
| lenBit | output | 1 | Current length select, 1 for long |
| failSafeReq | output | 1 | Pin held low past the release timeout |

## Verification
The stretcher is exercised with a lone strobe under each length setting. It is also driven with a second strobe inside a running pulse, with the length bit changed between the two strobes, and with two strobes in one cycle. These cases separate a counter that reloads from one that ignores retriggers, a length latched at the start from one read at each request, and a correct priority from a wrong one. External pulls are driven at three times: on an idle line, inside the block's own pulse, and held past the timeout. These show that own-drive edges are masked and that the release timer fires only when it should.

// File: rtl/rststr_pkg.sv
package rststr_pkg;
  localparam int CODE_W        = 4;
  localparam int CODE_NONE     = 0;
  localparam int CODE_POR      = 1;
  localparam int CODE_EXT      = 2;
  localparam int CODE_EVT_BASE = 3;

  localparam logic [1:0] MODE_NORMAL   = 2'd0;
  localparam logic [1:0] MODE_RESTART  = 2'd1;
  localparam logic [1:0] MODE_FAILSAFE = 2'd2;

  typedef enum logic [1:0] {ST_POR_WAIT, ST_IDLE, ST_PULSE} state_e;

  typedef struct packed {
    logic              loadCnt;
    logic              useLong;
    logic              logCode;
    logic [CODE_W-1:0] code;
    logic              startWatch;
  } ctrl_t;
endpackage

// File: rtl/rststr_ctrl.sv
module rststr_ctrl
  import rststr_pkg::*;
#(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyValid,
  input  logic [NUM_EVT-1:0] eventReq,
  input  logic               extFall,
  input  logic               lenBit,
  input  logic               cntZero,
  output ctrl_t              ctl,
  output logic               driveLow
);
  state_e state, stateNext;
  logic [CODE_W-1:0] evtCode;
  logic anyEvt;

  assign anyEvt = extFall || (|eventReq);

  // external pull outranks all strobes; among strobes the lowest index wins
  always_comb begin
    evtCode = CODE_W'(CODE_NONE);
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (eventReq[i]) evtCode = CODE_W'(CODE_EVT_BASE + i);
    end
    if (extFall) evtCode = CODE_W'(CODE_EXT);
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_POR_WAIT: begin
        if (supplyValid) begin
          ctl.loadCnt = 1'b1;
          ctl.useLong = 1'b0;
          ctl.logCode = 1'b1;
          ctl.code    = CODE_W'(CODE_POR);
          stateNext   = ST_PULSE;
        end
      end
      default: begin
        if (anyEvt) begin
          ctl.loadCnt    = 1'b1;
          ctl.useLong    = lenBit;
          ctl.logCode    = 1'b1;
          ctl.code       = evtCode;
          ctl.startWatch = extFall;
          stateNext      = ST_PULSE;
        end else if (state == ST_PULSE && cntZero) begin
          stateNext = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_POR_WAIT;
    else       state <= stateNext;
  end

  assign driveLow = (state != ST_IDLE);

  assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && cntZero && !anyEvt) |=> (state == ST_IDLE));
endmodule

// File: rtl/rststr_dp.sv
module rststr_dp
  import rststr_pkg::*;
#(
  parameter int SHORT_CYCLES    = 125000,
  parameter int LONG_CYCLES     = 2500000,
  parameter int RELEASE_TIMEOUT = 3750000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic              driveLow,
  input  logic              pinLevel,
  input  logic [1:0]        mode,
  input  logic              lenWrEn,
  input  logic              lenWrData,
  output logic              cntZero,
  output logic              extFall,
  output logic              lenBit,
  output logic [CODE_W-1:0] sourceCode,
  output logic              failSafeReq
);
  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam int TIM_W = $clog2(RELEASE_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [TIM_W-1:0] TIM_END    = TIM_W'(RELEASE_TIMEOUT);

  logic [CNT_W-1:0] cnt;
  logic [TIM_W-1:0] relTimer;
  logic pinMeta, pinSync, pinPrev, watching, recovery;

  // pin synchronizer and falling-edge detector, masked while driving
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b1;
      pinSync <= 1'b1;
      pinPrev <= 1'b1;
    end else begin
      pinMeta <= pinLevel;
      pinSync <= pinMeta;
      pinPrev <= pinSync;
    end
  end
  assign extFall = pinPrev && !pinSync && !driveLow;

  // stretch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (ctl.loadCnt)    cnt <= ctl.useLong ? LONG_LOAD : SHORT_LOAD;
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end
  assign cntZero = (cnt == '0);

  // length select: recovery modes force long, else software decides
  assign recovery = (mode == MODE_RESTART) || (mode == MODE_FAILSAFE);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lenBit <= 1'b0;
    else if (recovery) lenBit <= 1'b1;
    else if (lenWrEn)  lenBit <= lenWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sourceCode <= CODE_W'(CODE_NONE);
    else if (ctl.logCode) sourceCode <= ctl.code;
  end

  // external release watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      watching <= 1'b0;
      relTimer <= '0;
    end else if (ctl.startWatch) begin
      watching <= 1'b1;
      relTimer <= '0;
    end else if (watching) begin
      if (!driveLow && pinSync) begin
        watching <= 1'b0;
        relTimer <= '0;
      end else if (relTimer != TIM_END) begin
        relTimer <= relTimer + TIM_W'(1);
      end
    end
  end
  assign failSafeReq = watching && (relTimer == TIM_END);

  assert_reload_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCnt |=> (cnt == ($past(ctl.useLong) ? LONG_LOAD : SHORT_LOAD)));
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadCnt && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_code_log_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.logCode |=> (sourceCode == $past(ctl.code)));
  assert_mode_forces_long_R7: assert property (@(posedge clk) disable iff (!rstN)
    recovery |=> lenBit);
endmodule

// File: rtl/rststr_top.sv
module rststr_top
  import rststr_pkg::*;
#(
  parameter int NUM_EVT         = 10,
  parameter int SHORT_CYCLES    = 125000,
  parameter int LONG_CYCLES     = 2500000,
  parameter int RELEASE_TIMEOUT = 3750000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyValid,
  input  logic [NUM_EVT-1:0] eventReq,
  input  logic [1:0]         mode,
  input  logic               lenWrEn,
  input  logic               lenWrData,
  input  logic               pinLevel,
  output logic               pinDriveLow,
  output logic [3:0]         sourceCode,
  output logic               lenBit,
  output logic               failSafeReq
);
  ctrl_t ctl;
  logic  cntZero, extFall;

  rststr_ctrl #(.NUM_EVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyValid(supplyValid), .eventReq(eventReq),
    .extFall(extFall), .lenBit(lenBit), .cntZero(cntZero),
    .ctl(ctl), .driveLow(pinDriveLow)
  );

  rststr_dp #(
    .SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES),
    .RELEASE_TIMEOUT(RELEASE_TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .driveLow(pinDriveLow),
    .pinLevel(pinLevel), .mode(mode), .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .cntZero(cntZero), .extFall(extFall), .lenBit(lenBit),
    .sourceCode(sourceCode), .failSafeReq(failSafeReq)
  );
endmodule

// File: tb/rststr_top_bench.sv
module rststr_top_bench;
  localparam int NE = 10, SH = 20, LG = 60, TO = 150;

  logic clk = 1'b0, rstN = 1'b0, supplyValid = 1'b0;
  logic [NE-1:0] eventReq = '0;
  logic [1:0] mode = 2'd0;
  logic lenWrEn = 1'b0, lenWrData = 1'b0, extPull = 1'b0;
  logic pinLevel, pinDriveLow, lenBit, failSafeReq;
  logic [3:0] sourceCode;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign pinLevel = !(pinDriveLow || extPull);

  rststr_top #(.NUM_EVT(NE), .SHORT_CYCLES(SH), .LONG_CYCLES(LG),
               .RELEASE_TIMEOUT(TO)) u_rststr_top (
    .clk(clk), .rstN(rstN), .supplyValid(supplyValid), .eventReq(eventReq),
    .mode(mode), .lenWrEn(lenWrEn), .lenWrData(lenWrData), .pinLevel(pinLevel),
    .pinDriveLow(pinDriveLow), .sourceCode(sourceCode), .lenBit(lenBit),
    .failSafeReq(failSafeReq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    while (pinDriveLow && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic fire(int idx);
    eventReq[idx] = 1'b1;
    @(negedge clk);
    eventReq = '0;
  endtask

  task automatic writeLen(logic v);
    lenWrEn = 1'b1; lenWrData = v;
    @(negedge clk);
    lenWrEn = 1'b0;
  endtask

  task automatic testResetAndPor();
    int n;
    repeat (3) @(negedge clk);
    check("R1 drive", pinDriveLow, 1); check("R1 code", sourceCode, 0);
    check("R1 len", lenBit, 0);        check("R1 fs", failSafeReq, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 wait drive", pinDriveLow, 1);
    writeLen(1'b1);
    supplyValid = 1'b1;
    @(negedge clk);
    measure(n);
    check("R2 por length", n, SH); check("R2 por code", sourceCode, 1);
    repeat (10) @(negedge clk);
    check("R8 own release no event", pinDriveLow, 0);
    check("R8 code kept", sourceCode, 1);
    writeLen(1'b0);
  endtask

  task automatic testLengths();
    int n;
    fire(4); measure(n);
    check("R3 short", n, SH); check("R4 code evt4", sourceCode, 7);
    writeLen(1'b1);
    check("R6 write 1", lenBit, 1);
    fire(0); measure(n);
    check("R3 long", n, LG); check("R4 code evt0", sourceCode, 3);
    writeLen(1'b0);
    check("R6 write 0", lenBit, 0);
  endtask

  task automatic testPriorityRetrigger();
    int n;
    eventReq[5] = 1'b1; eventReq[2] = 1'b1;
    @(negedge clk); eventReq = '0;
    check("R4 priority", sourceCode, 5);
    repeat (8) @(negedge clk);
    fire(9); measure(n);
    check("R5 restart short", n, SH); check("R5 newest code", sourceCode, 12);
    fire(1); repeat (5) @(negedge clk);
    writeLen(1'b1);
    fire(6); measure(n);
    check("R5 restart with new length", n, LG); check("R5 code", sourceCode, 9);
    writeLen(1'b0);
  endtask

  task automatic testMode();
    int n;
    mode = 2'd1; @(negedge clk);
    check("R7 restart forces", lenBit, 1);
    writeLen(1'b0);
    check("R7 write ignored", lenBit, 1);
    mode = 2'd0; writeLen(1'b0);
    mode = 2'd2; @(negedge clk); mode = 2'd0; @(negedge clk);
    check("R7 failsafe forces and holds", lenBit, 1);
    fire(3); measure(n);
    check("R7 long after recovery", n, LG);
    writeLen(1'b0);
    check("R7 software clears", lenBit, 0);
  endtask

  task automatic testExternal();
    int n;
    extPull = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 ext starts pulse", pinDriveLow, 1);
    check("R8 ext code", sourceCode, 2);
    extPull = 1'b0;
    measure(n);
    check("R8 pulse within short", (n <= SH) ? 1 : 0, 1);
    repeat (5) @(negedge clk);
    check("R9 no fs on timely release", failSafeReq, 0);
    fire(7); repeat (4) @(negedge clk);
    extPull = 1'b1;
    measure(n); repeat (6) @(negedge clk);
    check("R8 pull inside own pulse ignored", pinDriveLow, 0);
    check("R8 code unchanged", sourceCode, 10);
    extPull = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic testTimeout();
    extPull = 1'b1;
    repeat (100) @(negedge clk);
    check("R9 not before timeout", failSafeReq, 0);
    repeat (100) @(negedge clk);
    check("R9 fs raised", failSafeReq, 1);
    extPull = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 fs cleared", failSafeReq, 0);
    check("R8 rising pin no event", pinDriveLow, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testResetAndPor();
    testLengths();
    testPriorityRetrigger();
    testMode();
    testExternal();
    testTimeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule